// File: doc/BRIEF.md
# SDRAM Burst Refresh Request Scheduler

This block tells an SDRAM controller's command sequencer when to issue auto-refresh commands. It does not space refreshes by a count of system clock cycles. A slow 32 kHz reference clock paces them instead, and that clock runs apart from the fast system clock. Each rising edge of the reference clock adds a small burst of row refreshes to a pending count. The sequencer works the count down one refresh at a time through a request/acknowledge handshake.

A 2-bit rate field sets the burst size. The value 2'b10 gives two rows per tick, which covers a 4096-row array within a 64 ms refresh window. The value 2'b11 gives four rows per tick, which covers an 8192-row array within the same window. The value 2'b01 gives one row per tick. The value 2'b00 turns refresh off. Refresh must be on before any data is stored in the memory. The reference clock is brought into the system clock domain by a two-stage synchronizer. An edge detector then turns each of its rising edges into a single-cycle tick. Requests that are already pending survive a change of the rate field.

Top module: `refresh_burst_scheduler`

## Requirements
- R1: After a synchronous active-low reset, `refresh_req` is low and no refresh is pending.
- R2: With `rate_sel` = 2'b00, a reference rising edge queues no refresh, and `refresh_req` stays low.
- R3: With `rate_sel` = 2'b01, each reference rising edge queues exactly one refresh.
- R4: With `rate_sel` = 2'b10, each reference rising edge queues exactly two refreshes.
- R5: With `rate_sel` = 2'b11, each reference rising edge queues exactly four refreshes.
- R6: `refresh_req` stays high while the pending count is nonzero, even if no acknowledge arrives. Each clock edge that samples `refresh_ack` and `refresh_req` both high removes exactly one refresh. An acknowledge sampled while `refresh_req` is low has no effect.
- R7: A tick and an accepted acknowledge in the same cycle change the pending count by the burst size minus one.
- R8: The pending count saturates at 15 and does not wrap.
- R9: The rate field is sampled on the tick, so a change affects only later ticks. Refreshes already pending are still served, even after the field is set to 2'b00.
- R10: Only a rising edge of the reference clock queues refreshes. Holding the reference clock high, or a falling edge, adds nothing.
- R11: Asserting reset while refreshes are pending clears them, and `refresh_req` is low from the first clock edge that samples the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_32k | input | 1 | 32 kHz reference clock, asynchronous to `clk` |
| rate_sel | input | 2 | Refresh rate field: 00 off, 01 one, 10 two, 11 four rows per tick |
| refresh_ack | input | 1 | Sequencer accepts one refresh when sampled high together with `refresh_req` |
| refresh_req | output | 1 | High while at least one refresh is pending |

## Verification
A single tick is applied at each of the four rate codes, and the acknowledges are then drained. This separates the burst sizes from one another and from the off setting. Ticks are stacked without draining to show that they add up and that the count stops at 15 rather than wrapping. An acknowledge is timed to land on the same edge as a tick, which shows whether both updates are applied together or one is lost. Other sequences hold the reference clock high for a long time, acknowledge while nothing is pending, change the rate between ticks, and reset in the middle of a backlog. These tell apart level detection from edge detection, and sampling the rate on the tick from applying it to the backlog.

// File: rtl/refresh_sched_pkg.sv
// Package: shared types and the rate-to-burst mapping for the refresh scheduler.
// Assumes the rate field is two bits wide and that the largest burst is four rows.
package refresh_sched_pkg;

    localparam int BURST_W = 3;

    typedef enum logic [1:0] {
        RATE_OFF  = 2'b00,
        RATE_ONE  = 2'b01,
        RATE_TWO  = 2'b10,
        RATE_FOUR = 2'b11
    } rate_e;

    // Number of row refreshes queued per reference tick for a rate code.
    function automatic logic [BURST_W-1:0] burst_of(input rate_e rate);
        case (rate)
            RATE_ONE:  burst_of = BURST_W'(1);
            RATE_TWO:  burst_of = BURST_W'(2);
            RATE_FOUR: burst_of = BURST_W'(4);
            default:   burst_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/ref_tick_sync.sv
// Module: ref_tick_sync
// Brings the slow asynchronous reference clock into the system clock domain
// through a chain of SYNC_STAGES flops. It then emits a one-cycle tick for each
// rising edge it sees. Assumes the reference period is many system clock cycles.
module ref_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic tick_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain: stage 0 samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
    end

    // Delayed copy of the synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Rising edge of the synchronized reference gives the tick.
    always_comb tick_o = sync_q[SYNC_STAGES-1] & ~prev_q;

    // A tick never lasts longer than one cycle (R10).
    assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/burst_size_decode.sv
// Module: burst_size_decode
// Maps the rate field to the number of rows queued per tick.
// Assumes the field is sampled by the consumer only on a tick.
module burst_size_decode
    import refresh_sched_pkg::*;
(
    input  logic [1:0]         rate_i,
    output logic [BURST_W-1:0] burst_o
);

    // Pure decode from rate code to burst size.
    always_comb burst_o = burst_of(rate_e'(rate_i));

endmodule

// File: rtl/pending_refresh_counter.sv
// Module: pending_refresh_counter
// Holds the number of refreshes still owed. It adds a burst on each tick and
// removes one for each accepted acknowledge, and saturates at 2**CNT_W-1.
// Assumes burst values fit in BURST_W bits and that CNT_W >= BURST_W.
module pending_refresh_counter
    import refresh_sched_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [BURST_W-1:0] burst_i,
    input  logic               ack_i,
    output logic               req_o
);

    localparam int          SUM_W   = CNT_W + 2;
    localparam logic [SUM_W-1:0] SAT_VAL = SUM_W'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] count_q;
    logic [SUM_W-1:0] next_w;
    logic             dec_w;

    // An acknowledge counts only while a request is being shown.
    always_comb dec_w = ack_i & req_o;

    // Next count: add burst on tick, subtract accepted ack, clamp at saturation.
    always_comb begin
        next_w = SUM_W'(count_q);
        if (tick_i) next_w = next_w + SUM_W'(burst_i);
        if (dec_w)  next_w = next_w - SUM_W'(1);
        if (next_w > SAT_VAL) next_w = SAT_VAL;
    end

    // Pending count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= next_w[CNT_W-1:0];
    end

    // Request is shown whenever something is owed.
    always_comb req_o = (count_q != '0);

    // Accepted ack without tick removes exactly one refresh (R6).
    assert_ack_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && ack_i && req_o) |=> (count_q == $past(count_q) - CNT_W'(1)));

    // Without tick or ack the count holds (R6).
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !ack_i) |=> $stable(count_q));

    // Tick plus accepted ack nets burst minus one when below saturation (R7).
    assert_tick_ack_net_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ack_i && req_o &&
         (SUM_W'(count_q) + SUM_W'(burst_i) <= SAT_VAL + SUM_W'(1)))
        |=> (SUM_W'(count_q) == SUM_W'($past(count_q)) + SUM_W'($past(burst_i)) - SUM_W'(1)));

    // A tick that would overflow leaves the count at saturation (R8).
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !ack_i && (SUM_W'(count_q) + SUM_W'(burst_i) >= SAT_VAL))
        |=> (SUM_W'(count_q) == SAT_VAL));

endmodule

// File: rtl/refresh_burst_scheduler.sv
// Module: refresh_burst_scheduler (top)
// Generates SDRAM auto-refresh requests in bursts paced by a 32 kHz reference
// clock. Assumes rate_sel is quasi-static and that the sequencer acknowledges
// one refresh per accepted handshake.
module refresh_burst_scheduler
    import refresh_sched_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_clk_32k,
    input  logic [1:0] rate_sel,
    input  logic       refresh_ack,
    output logic       refresh_req
);

    logic               tick_w;
    logic [BURST_W-1:0] burst_w;

    ref_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_clk_32k),
        .tick_o   (tick_w)
    );

    burst_size_decode u_dec (
        .rate_i  (rate_sel),
        .burst_o (burst_w)
    );

    pending_refresh_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_w),
        .burst_i (burst_w),
        .ack_i   (refresh_ack),
        .req_o   (refresh_req)
    );

    // Reset drops the request at the next edge (R1, R11).
    assert_reset_clear_R11: assert property (@(posedge clk)
        !rst_n |=> !refresh_req);

    // A tick with refresh off and no ack leaves the request unchanged (R2).
    assert_off_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_w && rate_sel == 2'b00 && !refresh_ack) |=> $stable(refresh_req));

endmodule

// File: tb/tb_refresh_burst_scheduler.sv
module tb_refresh_burst_scheduler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk_32k = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       refresh_ack = 1'b0;
    logic       refresh_req;

    int tests = 0;
    int fails = 0;
    int handshakes = 0;
    bit finished = 0;
    int exp_q[$];

    always #5 clk = ~clk;

    refresh_burst_scheduler dut (
        .clk(clk), .rst_n(rst_n), .ref_clk_32k(ref_clk_32k),
        .rate_sel(rate_sel), .refresh_ack(refresh_ack), .refresh_req(refresh_req)
    );

    // Monitor: counts accepted handshakes at each edge.
    always @(posedge clk) if (rst_n && refresh_req && refresh_ack) handshakes++;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int burst(input logic [1:0] r);
        case (r)
            2'b01: return 1;
            2'b10: return 2;
            2'b11: return 4;
            default: return 0;
        endcase
    endfunction

    // Driver: one reference period; the rate is set before the rising edge.
    task automatic fire_tick(input logic [1:0] r);
        @(negedge clk);
        rate_sel = r;
        ref_clk_32k = 1'b1;
        repeat (5) @(negedge clk);
        ref_clk_32k = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Driver: expected total for the next drain goes on the scoreboard queue.
    task automatic expect_total(input int n);
        exp_q.push_back(n);
    endtask

    // Monitor side: drains with ack held high and compares against the queue.
    task automatic drain(input string req);
        int start;
        int guard;
        int exp;
        @(negedge clk);
        start = handshakes;
        refresh_ack = 1'b1;
        guard = 0;
        while (refresh_req && guard < 40) begin
            @(negedge clk);
            guard++;
        end
        refresh_ack = 1'b0;
        exp = exp_q.pop_front();
        check(req, handshakes - start, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        check("R1 req after reset", int'(refresh_req), 0);

        // R2: off rate queues nothing
        fire_tick(2'b00);
        check("R2 req with rate off", int'(refresh_req), 0);
        expect_total(0); drain("R2 drain with rate off");

        // R3, R4, R5: single ticks at each rate
        fire_tick(2'b01); expect_total(burst(2'b01)); drain("R3 one per tick");
        fire_tick(2'b10); expect_total(burst(2'b10)); drain("R4 two per tick");
        fire_tick(2'b11); expect_total(burst(2'b11)); drain("R5 four per tick");

        // R6: request holds without ack, single ack removes one
        fire_tick(2'b10);
        repeat (20) @(negedge clk);
        check("R6 req held while pending", int'(refresh_req), 1);
        refresh_ack = 1'b1; @(negedge clk); refresh_ack = 1'b0;
        check("R6 req after one ack", int'(refresh_req), 1);
        expect_total(1); drain("R6 remaining after one ack");

        // R6: ack while idle has no effect
        @(negedge clk);
        refresh_ack = 1'b1; repeat (3) @(negedge clk); refresh_ack = 1'b0;
        check("R6 idle ack req", int'(refresh_req), 0);
        fire_tick(2'b10); expect_total(2); drain("R6 idle ack ignored");

        // R7: tick and ack on the same edge (pending 2, burst 4 -> 5)
        fire_tick(2'b10);
        @(negedge clk);
        rate_sel = 2'b11;
        ref_clk_32k = 1'b1;
        @(posedge clk); @(posedge clk);   // sync stage 1, then tick visible
        @(negedge clk);
        refresh_ack = 1'b1;               // sampled on the counter-update edge
        @(negedge clk);
        refresh_ack = 1'b0;
        repeat (3) @(negedge clk);
        ref_clk_32k = 1'b0;
        repeat (5) @(negedge clk);
        expect_total(5); drain("R7 tick and ack together");

        // R8: saturation at 15
        repeat (4) fire_tick(2'b11);
        expect_total(15); drain("R8 saturate after four bursts of four");
        repeat (6) fire_tick(2'b11);
        expect_total(15); drain("R8 saturate after six bursts");

        // R9: rate change affects later ticks only; backlog still served
        fire_tick(2'b11);
        fire_tick(2'b01);
        expect_total(5); drain("R9 mixed rates");
        fire_tick(2'b10);
        @(negedge clk); rate_sel = 2'b00;
        repeat (4) @(negedge clk);
        check("R9 backlog kept after off", int'(refresh_req), 1);
        expect_total(2); drain("R9 backlog served after off");

        // R10: long high level gives one burst only
        @(negedge clk);
        rate_sel = 2'b10;
        ref_clk_32k = 1'b1;
        repeat (60) @(negedge clk);
        expect_total(2); drain("R10 held high one burst");
        ref_clk_32k = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 falling edge adds nothing", int'(refresh_req), 0);

        // R11: reset clears backlog
        fire_tick(2'b11);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 req after reset edge", int'(refresh_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 backlog cleared", int'(refresh_req), 0);
        expect_total(0); drain("R11 nothing to drain");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule